// File: doc/BRIEF.md
# Double-Buffered Display Configuration Register Bank

This block holds the configuration words of a display engine in two copies. Software writes a staging copy at any time through a simple word-addressed write port. The active copy drives the datapath, and it changes only on the cycle where a vertical blanking pulse arrives. All staged words move to the active copy at once, so a frame never sees a mix of old and new settings.

One extra word in the address map controls the copy. Bit 0 is the load request and bit 1 is the autoload-off flag. While autoload is on, every blanking pulse copies the staging words. Once software turns autoload off, a copy happens only when a load request is pending. The request bit stays readable as 1 until the copy has taken place and then drops to 0. Software polls for that before it starts staging the next frame.

A normal commit is one write of value 3 to the control word. That single write disables autoload and requests a load. The read port returns staging values. A second read port returns active values for debug.

Top module: `shadow_cfg_bank`

## Requirements
- R1: After reset every staging word and every active word is 0, and the control word reads 0, which means autoload is on and no request is pending.
- R2: A write to a data address in the range 0 to NUM_REGS-1 changes that staging word, and the read port returns the new value from the next cycle. The active outputs change only in the cycle after a blanking pulse.
- R3: When the autoload-off flag (control bit 1) is 1 and no request is pending, a blanking pulse leaves the active words unchanged.
- R4: When the autoload-off flag is 0, every blanking pulse copies all staging words to the active words, and the copy is visible in the next cycle.
- R5: The control word sits at address NUM_REGS, and its bit 0 is the load request. Writing 1 to bit 0 sets the request. Writing 0 to bit 0 does not cancel a pending request. The request reads 1 until a blanking pulse performs the copy, and reads 0 from the next cycle on.
- R6: A single write of value 3 to the control word turns autoload off and requests a load. The next blanking pulse copies the staging words. A later blanking pulse with no new request changes nothing.
- R7: A data write in the same cycle as a blanking pulse updates only the staging word. The active word takes the staging value from before that write, and the new value moves over at the next load.
- R8: A control write that sets the request in the same cycle as a blanking pulse leaves the request pending after that pulse. That pulse copies the staging words only if autoload was already on or a request was already pending.
- R9: The debug port returns the active word at the given address. Addresses above NUM_REGS read 0 on both ports, and writes to them have no effect. The control address reads 0 on the debug port.
- R10: Writing 0 to every data address and then committing clears all active words, whatever values they held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Word address of the staging/control read |
| rd_data | output | DATA_W | Staging word or control word, combinational |
| dbg_addr | input | ADDR_W | Word address of the active-copy read |
| dbg_data | output | DATA_W | Active word, combinational |
| vblank | input | 1 | One-cycle vertical blanking pulse |
| active_cfg | output | NUM_REGS*DATA_W | All active words, word i at bits i*DATA_W upward |

## Verification
The hardest situations to reach are the collisions at the blanking cycle. One is a data write that lands in the same cycle as the pulse. Another is a control write that sets the request in that cycle, both with and without an earlier pending request. Directed tasks drive the write strobe and the pulse together in one cycle to create each collision, and the active words and the request bit are then read back on the following cycle. A long random phase then mixes writes to data, control and out-of-range addresses with random pulses. A behavioural reference model is compared with every output on every cycle.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    localparam int CTRL_REQ_BIT = 0;
    localparam int CTRL_OFF_BIT = 1;

    typedef struct packed {
        logic autoload_off;
        logic load_req;
    } sreg_ctrl_t;
endpackage

// File: rtl/sreg_ctrl.sv
module sreg_ctrl
    import sreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic       set_req,
    input  logic       set_off,
    input  logic       vblank,
    output logic       load_now,
    output sreg_ctrl_t ctrl_q
);
    sreg_ctrl_t ctrl_d;

    always_comb begin
        ctrl_d   = ctrl_q;
        load_now = vblank && (ctrl_q.load_req || !ctrl_q.autoload_off);
        if (load_now) begin
            ctrl_d.load_req = 1'b0;
        end
        if (ctrl_wr) begin
            ctrl_d.autoload_off = set_off;
            if (set_req) begin
                ctrl_d.load_req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             data_wr,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic                             load_now,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  shadow_q,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  active_q
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] shadow;
        logic [NUM_REGS-1:0][DATA_W-1:0] active;
    } bank_t;

    bank_t               bank_d;
    bank_t               bank_q;
    logic [NUM_REGS-1:0] hit_d;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
        assign hit_d[g] = data_wr && (wr_idx == IDX_W'(g));
    end

    always_comb begin
        bank_d = bank_q;
        if (load_now) begin
            bank_d.active = bank_q.shadow;
        end
        for (int i = 0; i < NUM_REGS; i++) begin
            if (hit_d[i]) begin
                bank_d.shadow[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign shadow_q = bank_q.shadow;
    assign active_q = bank_q.active;
endmodule

// File: rtl/sreg_rdport.sv
module sreg_rdport #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = $clog2(NUM_REGS + 1)
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] words,
    input  logic [ADDR_W-1:0]               addr,
    input  logic                            extra_en,
    input  logic [DATA_W-1:0]               extra_val,
    output logic [DATA_W-1:0]               data
);
    localparam int IDX_W = $clog2(NUM_REGS);

    always_comb begin
        data = '0;
        if (addr < ADDR_W'(NUM_REGS)) begin
            data = words[addr[IDX_W-1:0]];
        end else if (addr == ADDR_W'(NUM_REGS) && extra_en) begin
            data = extra_val;
        end
    end
endmodule

// File: rtl/shadow_cfg_bank.sv
module shadow_cfg_bank
    import sreg_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = $clog2(NUM_REGS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    input  logic [ADDR_W-1:0]          dbg_addr,
    output logic [DATA_W-1:0]          dbg_data,
    input  logic                       vblank,
    output logic [NUM_REGS*DATA_W-1:0] active_cfg
);
    localparam int IDX_W = $clog2(NUM_REGS);

    sreg_ctrl_t                      ctrl_q;
    logic                            load_now;
    logic                            ctrl_wr;
    logic                            data_wr;
    logic [NUM_REGS-1:0][DATA_W-1:0] shadow_w;
    logic [NUM_REGS-1:0][DATA_W-1:0] active_w;
    logic [NUM_REGS*DATA_W-1:0]      shadow_flat;
    logic [DATA_W-1:0]               ctrl_word;
    logic                            req_q;
    logic                            off_q;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(NUM_REGS));
    assign data_wr = wr_en && (wr_addr < ADDR_W'(NUM_REGS));

    sreg_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .set_req  (wr_data[CTRL_REQ_BIT]),
        .set_off  (wr_data[CTRL_OFF_BIT]),
        .vblank   (vblank),
        .load_now (load_now),
        .ctrl_q   (ctrl_q)
    );

    sreg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_wr  (data_wr),
        .wr_idx   (wr_addr[IDX_W-1:0]),
        .wr_data  (wr_data),
        .load_now (load_now),
        .shadow_q (shadow_w),
        .active_q (active_w)
    );

    assign req_q       = ctrl_q.load_req;
    assign off_q       = ctrl_q.autoload_off;
    assign ctrl_word   = {{(DATA_W-2){1'b0}}, off_q, req_q};
    assign shadow_flat = shadow_w;
    assign active_cfg  = active_w;

    sreg_rdport #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_shadow (
        .words     (shadow_w),
        .addr      (rd_addr),
        .extra_en  (1'b1),
        .extra_val (ctrl_word),
        .data      (rd_data)
    );

    sreg_rdport #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_active (
        .words     (active_w),
        .addr      (dbg_addr),
        .extra_en  (1'b0),
        .extra_val (ctrl_word),
        .data      (dbg_data)
    );
endmodule

// File: rtl/sreg_bank_chk.sv
module sreg_bank_chk #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = $clog2(NUM_REGS + 1)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       vblank,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic                       data_bit0,
    input logic                       req_q,
    input logic                       off_q,
    input logic [NUM_REGS*DATA_W-1:0] shadow_flat,
    input logic [NUM_REGS*DATA_W-1:0] active_cfg
);
    logic req_set;
    assign req_set = wr_en && (wr_addr == ADDR_W'(NUM_REGS)) && data_bit0;

    // R2
    active_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vblank |=> $stable(active_cfg));

    // R3
    no_autoload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank && off_q && !req_q) |=> $stable(active_cfg));

    // R4
    autoload_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank && !off_q) |=> (active_cfg == $past(shadow_flat)));

    // R6
    request_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank && req_q) |=> (active_cfg == $past(shadow_flat)));

    // R5
    req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank && req_q && !req_set) |=> !req_q);

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !vblank) |=> req_q);

    // R8
    req_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_set |=> req_q);
endmodule

bind shadow_cfg_bank sreg_bank_chk #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vblank      (vblank),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .data_bit0   (wr_data[0]),
    .req_q       (req_q),
    .off_q       (off_q),
    .shadow_flat (shadow_flat),
    .active_cfg  (active_cfg)
);

// File: tb/tb_shadow_cfg_bank.sv
module tb_shadow_cfg_bank;
    localparam int NR      = 16;
    localparam int DW      = 32;
    localparam int AW      = $clog2(NR + 1);
    localparam int CLK_PER = 10;
    localparam int CTRL    = NR;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] dbg_addr = '0;
    logic [DW-1:0] dbg_data;
    logic vblank = 1'b0;
    logic [NR*DW-1:0] active_cfg;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PER/2) clk = ~clk;

    shadow_cfg_bank #(.NUM_REGS(NR), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .dbg_addr(dbg_addr), .dbg_data(dbg_data), .vblank(vblank),
        .active_cfg(active_cfg)
    );

    // behavioural reference
    logic [DW-1:0] m_sh [NR];
    logic [DW-1:0] m_ac [NR];
    bit m_req;
    bit m_off;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) begin m_sh[i] = '0; m_ac[i] = '0; end
            m_req = 0;
            m_off = 0;
        end else begin
            bit copy;
            copy = vblank && (m_req || !m_off);
            if (copy) begin
                for (int i = 0; i < NR; i++) m_ac[i] = m_sh[i];
                m_req = 0;
            end
            if (wr_en && int'(wr_addr) == CTRL) begin
                m_off = wr_data[1];
                if (wr_data[0]) m_req = 1;
            end
            if (wr_en && int'(wr_addr) < NR) m_sh[int'(wr_addr)] = wr_data;
        end
    end

    function automatic logic [DW-1:0] exp_rd(int a);
        if (a < NR) return m_sh[a];
        if (a == CTRL) return {{(DW-2){1'b0}}, m_off, m_req};
        return '0;
    endfunction

    function automatic logic [DW-1:0] exp_dbg(int a);
        if (a < NR) return m_ac[a];
        return '0;
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (rd_data !== exp_rd(int'(rd_addr))) begin
                fails++;
                $display("FAIL R2 read port addr %0d act=%h exp=%h", rd_addr, rd_data, exp_rd(int'(rd_addr)));
            end
            checks++;
            if (dbg_data !== exp_dbg(int'(dbg_addr))) begin
                fails++;
                $display("FAIL R9 debug port addr %0d act=%h exp=%h", dbg_addr, dbg_data, exp_dbg(int'(dbg_addr)));
            end
            for (int i = 0; i < NR; i++) begin
                checks++;
                if (active_cfg[i*DW +: DW] !== m_ac[i]) begin
                    fails++;
                    $display("FAIL R4 active word %0d act=%h exp=%h", i, active_cfg[i*DW +: DW], m_ac[i]);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(int a, logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic vb();
        vblank = 1'b1;
        step();
        vblank = 1'b0;
    endtask

    task automatic wr_vb(int a, logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; vblank = 1'b1;
        step();
        wr_en = 1'b0; vblank = 1'b0;
    endtask

    task automatic rd_chk(int a, logic [DW-1:0] exp, string tag);
        rd_addr = AW'(a);
        @(negedge clk);
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s read addr %0d act=%h exp=%h", tag, a, rd_data, exp);
        end
        step();
    endtask

    task automatic dbg_chk(int a, logic [DW-1:0] exp, string tag);
        dbg_addr = AW'(a);
        @(negedge clk);
        checks++;
        if (dbg_data !== exp) begin
            fails++;
            $display("FAIL %s debug addr %0d act=%h exp=%h", tag, a, dbg_data, exp);
        end
        step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();

        // R1 reset state
        rd_chk(CTRL, 32'h0, "R1");
        rd_chk(5, 32'h0, "R1");
        dbg_chk(5, 32'h0, "R1");

        // R2 staging write, active untouched
        wr(3, 32'h0000_00A5);
        rd_chk(3, 32'h0000_00A5, "R2");
        dbg_chk(3, 32'h0, "R2");

        // R4 autoload copies on pulse
        vb();
        dbg_chk(3, 32'h0000_00A5, "R4");

        // R3 autoload off, no request
        wr(CTRL, 32'h2);
        wr(3, 32'h11);
        vb();
        dbg_chk(3, 32'h0000_00A5, "R3");
        rd_chk(CTRL, 32'h2, "R3");

        // R6 single commit write; R5 request behaviour
        wr(CTRL, 32'h3);
        rd_chk(CTRL, 32'h3, "R5");
        wr(CTRL, 32'h2);
        rd_chk(CTRL, 32'h3, "R5");
        vb();
        dbg_chk(3, 32'h11, "R6");
        rd_chk(CTRL, 32'h2, "R5");
        wr(3, 32'h22);
        vb();
        dbg_chk(3, 32'h11, "R6");

        // R7 data write collides with pulse
        wr(CTRL, 32'h3);
        wr_vb(3, 32'h33);
        dbg_chk(3, 32'h22, "R7");
        rd_chk(3, 32'h33, "R7");
        wr(CTRL, 32'h3);
        vb();
        dbg_chk(3, 32'h33, "R7");

        // R8 request set in pulse cycle, nothing pending before
        wr(3, 32'h44);
        wr_vb(CTRL, 32'h3);
        dbg_chk(3, 32'h33, "R8");
        rd_chk(CTRL, 32'h3, "R8");
        vb();
        dbg_chk(3, 32'h44, "R8");
        // R8 request already pending, set again in pulse cycle
        wr(CTRL, 32'h3);
        wr(3, 32'h55);
        wr_vb(CTRL, 32'h3);
        dbg_chk(3, 32'h55, "R8");
        rd_chk(CTRL, 32'h3, "R8");
        vb();

        // R9 out-of-range addresses
        wr(NR + 3, 32'hFFFF_FFFF);
        rd_chk(NR + 3, 32'h0, "R9");
        dbg_chk(NR + 3, 32'h0, "R9");
        dbg_chk(CTRL, 32'h0, "R9");
        rd_chk(CTRL, 32'h2, "R9");

        // R10 zero sweep
        for (int i = 0; i < NR; i++) wr(i, 32'hDEAD_0000 | DW'(i + 1));
        wr(CTRL, 32'h3);
        vb();
        dbg_chk(NR - 1, 32'hDEAD_0000 | DW'(NR), "R10");
        for (int i = 0; i < NR; i++) wr(i, 32'h0);
        wr(CTRL, 32'h3);
        vb();
        for (int i = 0; i < NR; i++) dbg_chk(i, 32'h0, "R10");

        // random mix, checked each cycle by the model
        for (int n = 0; n < 600; n++) begin
            wr_en   = ($urandom % 3) == 0;
            wr_addr = AW'($urandom % (1 << AW));
            wr_data = ($urandom % 4 == 0) ? DW'($urandom % 4) : DW'($urandom);
            vblank  = ($urandom % 5) == 0;
            rd_addr = AW'($urandom % (NR + 2));
            dbg_addr = AW'($urandom % (NR + 2));
            step();
        end
        wr_en = 1'b0;
        vblank = 1'b0;
        step();
        finish_run();
    end
endmodule